// File: doc/BRIEF.md
# Byte-Port Decoder for a Separate I/O Space

This block sits on the I/O side of a processor bus, where port addresses form a 64K space apart from memory. It watches a 16-bit port address, a read strobe, a write strobe and a transfer-size code. From these it serves two byte-wide peripherals placed at a parameterised base address. The first is an input port that places a bank of external switches onto the read-data bus. The second is an output latch that drives a row of active-low LEDs.

A word or doubleword transfer is split into consecutive byte ports. Byte lane k of the data buses belongs to port address `addr_i + k`, so the lowest address carries the least significant byte. Any lane in a read that lands on a port with nothing behind it returns 0xFF. A parameter selects one of two decode modes. In full mode all 16 address bits are compared. In reduced mode only the low 8 bits are compared, which costs less logic in small systems. The read path is a gated internal mux, so it produces zeros when not selected instead of a floating bus.

Top module: `io_port_decoder`

## Requirements
- R1: `size_i` sets how many byte lanes a transfer covers: code 0 is one lane, code 1 is two lanes, and codes 2 and 3 are four lanes. Lane k (bits 8k+7:8k of `rdata_o` and `wdata_i`) maps to port address `addr_i + k` modulo 65536, so it wraps past 0xFFFF.
- R2: With `FULL_DECODE=1` a lane matches a port only when all 16 address bits are equal. With `FULL_DECODE=0` only bits 7:0 are compared and bits 15:8 are ignored.
- R3: While `io_rd_i` is high, a covered lane whose address is `BASE_ADDR+IN_OFS` shows `sw_i` in the same cycle, and `in_sel_no` is low. In every other case `in_sel_no` is high.
- R4: While `io_rd_i` is high, a covered lane that matches no readable port reads 0xFF. This includes the write-only latch address.
- R5: Lanes outside the transfer size read 0x00. All of `rdata_o` is 0 while `io_rd_i` is low.
- R6: While `io_wr_i` is high and a covered lane addresses `BASE_ADDR+OUT_OFS`, `out_sel_no` is low in that cycle. At the next rising clock edge `led_no` takes that lane's `wdata_i` byte.
- R7: `led_no` holds its value in every cycle without such a write. A write to any other port, or with `io_wr_i` low, leaves it unchanged.
- R8: During and after reset, `led_no` is 0xFF, which turns all LEDs off because a 0 bit lights an LED.
- R9: When neither strobe is active, `in_sel_no` and `out_sel_no` both stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Port address of the current cycle |
| io_rd_i | input | 1 | I/O read strobe, active high |
| io_wr_i | input | 1 | I/O write strobe, active high |
| size_i | input | 2 | Transfer size: 0 byte, 1 word, 2/3 doubleword |
| wdata_i | input | 32 | Write data, byte lane k for address+k |
| sw_i | input | 8 | Switch levels behind the input port |
| rdata_o | output | 32 | Gated read data |
| in_sel_no | output | 1 | Input port select, active low |
| out_sel_no | output | 1 | Output latch write select, active low |
| led_no | output | 8 | Latched LED drive, active low |

## Verification
Read data and both selects are combinational, so they are due in the same cycle as the address and strobes. The LED latch changes only at the rising edge that follows a write cycle. The bench applies each stimulus just after a falling edge and checks `rdata_o`, `in_sel_no` and `out_sel_no` one time unit later. It checks `led_no` at the next falling edge, which follows exactly one rising edge. Two instances are run side by side, one per decode mode, and each is compared against its own bench model.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWALT = 2'd3
  } xfer_size_e;

  localparam int unsigned MAX_LANES = 8;

  // lanes covered by a transfer, lane 0 = lowest port address
  function automatic logic [MAX_LANES-1:0] size_mask(xfer_size_e sz);
    logic [MAX_LANES-1:0] m;
    unique case (sz)
      SZ_BYTE: m = MAX_LANES'(8'h01);
      SZ_WORD: m = MAX_LANES'(8'h03);
      default: m = MAX_LANES'(8'h0F);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/io_lane_decode.sv
module io_lane_decode #(
  parameter int unsigned            ADDR_W      = 16,
  parameter int unsigned            LANES       = 4,
  parameter logic [ADDR_W-1:0]      BASE_ADDR   = 16'h0300,
  parameter int unsigned            OFS         = 0,
  parameter bit                     FULL_DECODE = 1'b1,
  parameter int unsigned            LOW_W       = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic [LANES-1:0]  hit_o
);

  localparam int unsigned       CMP_W     = FULL_DECODE ? ADDR_W : LOW_W;
  localparam logic [ADDR_W-1:0] PORT_ADDR = BASE_ADDR + ADDR_W'(OFS);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr = addr_i + ADDR_W'(k);
    assign hit_o[k]  = lane_en_i[k] && (lane_addr[CMP_W-1:0] == PORT_ADDR[CMP_W-1:0]);
  end

endmodule

// File: rtl/io_rd_mux.sv
module io_rd_mux #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = PORT_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [LANES-1:0]  in_hit_i,
  input  logic [PORT_W-1:0] sw_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (!rd_en_i || !lane_en_i[k])  rdata_o[k*PORT_W +: PORT_W] = '0;
      else if (in_hit_i[k])           rdata_o[k*PORT_W +: PORT_W] = sw_i;
      else                            rdata_o[k*PORT_W +: PORT_W] = '1;  // unpopulated port
    end
  end

  // R5
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);

endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
  parameter int unsigned       PORT_W    = 8,
  parameter int unsigned       LANES     = 4,
  parameter logic [PORT_W-1:0] RESET_VAL = '1,
  localparam int unsigned      DATA_W    = PORT_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LANES-1:0]  hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              sel_no,
  output logic [PORT_W-1:0] led_no
);

  logic [PORT_W-1:0] wr_byte;
  logic              wr_sel;

  assign wr_sel = wr_en_i && (|hit_i);
  assign sel_no = ~wr_sel;

  // lowest hitting lane wins
  always_comb begin
    wr_byte = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (hit_i[k]) wr_byte = wdata_i[k*PORT_W +: PORT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     led_no <= RESET_VAL;
    else if (wr_sel) led_no <= wr_byte;
  end

  // R6
  latch_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_no |=> led_no == $past(wr_byte));

  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_no |=> $stable(led_no));

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 16,
  parameter int unsigned        PORT_W      = 8,
  parameter int unsigned        DATA_W      = 32,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = 16'h0300,
  parameter int unsigned        IN_OFS      = 0,
  parameter int unsigned        OUT_OFS     = 1,
  parameter bit                 FULL_DECODE = 1'b1,
  parameter int unsigned        LOW_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] sw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              in_sel_no,
  output logic              out_sel_no,
  output logic [PORT_W-1:0] led_no
);

  localparam int unsigned LANES = DATA_W / PORT_W;

  logic [MAX_LANES-1:0] full_mask;
  logic [LANES-1:0]     lane_en;
  logic [LANES-1:0]     in_hit;
  logic [LANES-1:0]     out_hit;

  assign full_mask = size_mask(xfer_size_e'(size_i));
  assign lane_en   = full_mask[LANES-1:0];

  io_lane_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BASE_ADDR(BASE_ADDR),
    .OFS(IN_OFS), .FULL_DECODE(FULL_DECODE), .LOW_W(LOW_W)
  ) u_in_dec (
    .addr_i(addr_i), .lane_en_i(lane_en), .hit_o(in_hit)
  );

  io_lane_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BASE_ADDR(BASE_ADDR),
    .OFS(OUT_OFS), .FULL_DECODE(FULL_DECODE), .LOW_W(LOW_W)
  ) u_out_dec (
    .addr_i(addr_i), .lane_en_i(lane_en), .hit_o(out_hit)
  );

  io_rd_mux #(.PORT_W(PORT_W), .LANES(LANES)) u_rd_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(io_rd_i), .lane_en_i(lane_en),
    .in_hit_i(in_hit), .sw_i(sw_i), .rdata_o(rdata_o)
  );

  assign in_sel_no = ~(io_rd_i && (|in_hit));

  io_out_latch #(.PORT_W(PORT_W), .LANES(LANES)) u_out_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(io_wr_i), .hit_i(out_hit),
    .wdata_i(wdata_i), .sel_no(out_sel_no), .led_no(led_no)
  );

  // R9
  no_strobe_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_rd_i || io_wr_i) |-> (in_sel_no && out_sel_no));

  // R3
  in_sel_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sel_no |-> io_rd_i);

  // R1
  single_in_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_hit));

  // R1
  single_out_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_hit));

endmodule

// File: tb/io_port_decoder_test.sv
module io_port_decoder_test;

  localparam int          CLK_P = 10;
  localparam logic [15:0] BASE  = 16'h0300;
  localparam logic [15:0] A_IN  = BASE;
  localparam logic [15:0] A_OUT = BASE + 16'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  sw = '0;

  logic [31:0] rdata_f, rdata_l;
  logic        isel_f, isel_l, osel_f, osel_l;
  logic [7:0]  led_f, led_l;

  logic [7:0]  mled_f, mled_l;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  io_port_decoder #(.BASE_ADDR(BASE), .FULL_DECODE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .io_rd_i(rd), .io_wr_i(wr),
    .size_i(size), .wdata_i(wdata), .sw_i(sw), .rdata_o(rdata_f),
    .in_sel_no(isel_f), .out_sel_no(osel_f), .led_no(led_f));

  io_port_decoder #(.BASE_ADDR(BASE), .FULL_DECODE(1'b0)) uut_lo (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .io_rd_i(rd), .io_wr_i(wr),
    .size_i(size), .wdata_i(wdata), .sw_i(sw), .rdata_o(rdata_l),
    .in_sel_no(isel_l), .out_sel_no(osel_l), .led_no(led_l));

  function automatic int nlanes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit match(logic [15:0] a, logic [15:0] p, bit full);
    return full ? (a == p) : (a[7:0] == p[7:0]);
  endfunction

  // lane index hitting port p, or -1
  function automatic int hit_lane(logic [15:0] a, logic [1:0] s, logic [15:0] p, bit full);
    for (int k = 0; k < nlanes(s); k++)
      if (match(a + 16'(k), p, full)) return k;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [15:0] a, logic [1:0] s, logic r,
                                         logic [7:0] w, bit full);
    logic [31:0] v = '0;
    if (!r) return v;
    for (int k = 0; k < nlanes(s); k++)
      v[k*8 +: 8] = match(a + 16'(k), A_IN, full) ? w : 8'hFF;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (addr=%h size=%0d rd=%b wr=%b)",
               req, act, exp, addr, size, rd, wr);
    end
  endtask

  // apply one bus cycle after a falling edge, check combinational results
  task automatic cycle(logic [15:0] a, logic [1:0] s, logic r, logic w,
                       logic [31:0] d, logic [7:0] swv, string tag);
    int lf, ll;
    @(negedge clk);
    chk({tag, " R7 led full"}, 32'(led_f), 32'(mled_f));
    chk({tag, " R7 led low"},  32'(led_l), 32'(mled_l));
    addr = a; size = s; rd = r; wr = w; wdata = d; sw = swv;
    #1;
    chk({tag, " R3/R4/R5 rdata full"}, rdata_f, exp_rd(a, s, r, swv, 1'b1));
    chk({tag, " R2 rdata low"},        rdata_l, exp_rd(a, s, r, swv, 1'b0));
    chk({tag, " R3 in_sel full"}, 32'(isel_f), 32'(!(r && hit_lane(a, s, A_IN, 1'b1) >= 0)));
    chk({tag, " R3 in_sel low"},  32'(isel_l), 32'(!(r && hit_lane(a, s, A_IN, 1'b0) >= 0)));
    lf = hit_lane(a, s, A_OUT, 1'b1);
    ll = hit_lane(a, s, A_OUT, 1'b0);
    chk({tag, " R6 out_sel full"}, 32'(osel_f), 32'(!(w && lf >= 0)));
    chk({tag, " R6 out_sel low"},  32'(osel_l), 32'(!(w && ll >= 0)));
    if (w && lf >= 0) mled_f = d[lf*8 +: 8];
    if (w && ll >= 0) mled_l = d[ll*8 +: 8];
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    mled_f = 8'hFF; mled_l = 8'hFF;
    #(CLK_P * 2);
    // R8 reset state
    chk("R8 led full in reset", 32'(led_f), 32'hFF);
    chk("R8 led low in reset",  32'(led_l), 32'hFF);
    @(negedge clk); rst_n = 1'b1;

    // R9 no strobe, address on the latch
    cycle(A_OUT, 2'd0, 1'b0, 1'b0, 32'h1234_5600, 8'h5A, "R9 idle");
    chk("R9 in_sel idle", 32'(isel_f), 32'd1);
    // R6 byte write to latch
    cycle(A_OUT, 2'd0, 1'b0, 1'b1, 32'h0000_00A5, 8'h00, "R6 byte");
    // R1 word from base: lane0 switches, lane1 latch reads FF (R4)
    cycle(A_IN, 2'd1, 1'b1, 1'b0, 32'h0, 8'h3C, "R1 word rd");
    // R1 word write from base-0: latch in lane1
    cycle(A_IN, 2'd1, 1'b0, 1'b1, 32'h0000_7E11, 8'h00, "R1 word wr");
    // R1 dword starting below base: in lane 2, out lane 3
    cycle(BASE - 16'd2, 2'd2, 1'b1, 1'b1, 32'hC3_00_00_00, 8'h96, "R1 dword");
    cycle(BASE - 16'd3, 2'd3, 1'b1, 1'b0, 32'h0, 8'h81, "R1 dword alt");
    // R5 byte read off-port: one lane FF, rest zero
    cycle(16'h1000, 2'd0, 1'b1, 1'b0, 32'h0, 8'h00, "R4 unpopulated");
    // R2 alias: upper byte differs, only reduced decode hits
    cycle(16'hAB01, 2'd0, 1'b1, 1'b1, 32'h0000_0042, 8'hE7, "R2 alias wr");
    cycle(16'hAB00, 2'd1, 1'b1, 1'b0, 32'h0, 8'h18, "R2 alias rd");
    // R1 wrap across 0xFFFF
    cycle(16'hFFFE, 2'd2, 1'b1, 1'b1, 32'h55_66_77_88, 8'h24, "R1 wrap");
    // R7 write to unpopulated port with full decode
    cycle(16'h0302, 2'd0, 1'b0, 1'b1, 32'h0000_0000, 8'h00, "R7 other port");

    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      if ($urandom_range(9) < 7) a = BASE + 16'($urandom_range(6)) - 16'd3;
      else if ($urandom_range(1) == 1) a = {8'($urandom), BASE[7:0] + 8'($urandom_range(3)) - 8'd1};
      else a = 16'($urandom);
      cycle(a, 2'($urandom), 1'($urandom), 1'($urandom), $urandom, 8'($urandom), "rand");
    end
    @(negedge clk);
    chk("R7 final led full", 32'(led_f), 32'(mled_f));
    chk("R7 final led low",  32'(led_l), 32'(mled_l));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule